// File: doc/BRIEF.md
# Trap-Return Privilege State Updater

This block carries out the two trap-return operations of a RISC-V style core: the supervisor return and the machine return. A request strobe arrives with a return-type select. The core also supplies its current privilege level, its virtualization flag, the machine and hypervisor status words, the two saved return addresses, and a small configuration: compressed instructions present, hypervisor support present, address protection present, and the number of protection rules configured.

The block first decides whether the return is allowed, using a fixed priority order. A legal return produces a new status word, a new hypervisor status word, a new privilege level, a new virtualization flag and the return address. An illegal return produces only an exception cause and hands back the status unchanged. All results are registered and appear one clock cycle after the request. The core writes them back on the commit strobe.

When the restored virtualization flag is 1, the block asks for an exchange of the hypervisor register banks with a one-cycle strobe. The block does not perform that exchange itself.

Top module: `xret_unit`

## Requirements
- R1: After a synchronous reset, every output is 0: the strobes, the cause, the return PC, the privilege, the virtualization flag and both status words.
- R2: Each request cycle produces exactly one `done_o` pulse in the next cycle. That cycle carries either `commit_o` or `exc_o`, never both. Back-to-back requests give back-to-back results. Without a request, all strobes stay low.
- R3: A supervisor return issued at user level (privilege encoding U=0, S=1, M=3) raises illegal instruction (cause 2). This check ranks above all other checks.
- R4: Without compressed support, a return target with nonzero bits [1:0] raises address misaligned (cause 0). This check ranks second, after the privilege check. With compressed support, the low bits are not checked.
- R5: A supervisor return with the trap-supervisor-return bit (status bit 22) set raises cause 2 below machine level. At machine level the return proceeds.
- R6: With hypervisor support, a supervisor return issued while virtualized with the virtual-trap bit (hypervisor status bit 22) set raises virtual instruction (cause 22).
- R7: A legal supervisor return with hypervisor support, issued while not virtualized, works as follows. The new privilege is {0, SPP} (status bit 8). The new virtualization flag is the saved SPV (hypervisor status bit 7). SPV and SPP are cleared, SIE (bit 1) takes SPIE (bit 5), SPIE becomes 1, and the return PC is the supervisor return address.
- R8: Any other legal supervisor return performs the same status and privilege update as R7. It leaves the virtualization flag and the hypervisor status word unchanged.
- R9: A machine return below machine level raises cause 2. A legal machine return works as follows. The privilege comes from MPP (bits 12:11), MIE (bit 3) takes MPIE (bit 7), MPIE becomes 1, MPP becomes 0 and MPV (bit 39) is cleared. With hypervisor support, virtualization takes the old MPV; without it, the flag is unchanged.
- R10: With address protection present, zero rules configured and an MPP other than M, a machine return raises cause 2. This check ranks after the misaligned check.
- R11: `swap_o` pulses together with `commit_o` exactly when the virtualization flag is restored from a saved value of 1 (R7 or R9 with hypervisor support).
- R12: On an exception, both status words, the privilege and the virtualization flag are output unchanged, and `commit_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Return request strobe |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| mstatus_i | input | XLEN | Machine status word |
| hstatus_i | input | XLEN | Hypervisor status word |
| sepc_i | input | XLEN | Supervisor saved return address |
| mepc_i | input | XLEN | Machine saved return address |
| cfg_has_c | input | 1 | Compressed instructions supported |
| cfg_has_h | input | 1 | Hypervisor support present |
| cfg_has_pmp | input | 1 | Address protection present |
| cfg_pmp_rules | input | RULE_W | Number of protection rules configured |
| done_o | output | 1 | Result valid, one cycle after a request |
| commit_o | output | 1 | Return is legal; write results back |
| exc_o | output | 1 | Return raised an exception |
| cause_o | output | 5 | Exception cause (0 on commit) |
| ret_pc_o | output | XLEN | Selected return target |
| priv_o | output | 2 | New privilege level |
| virt_o | output | 1 | New virtualization flag |
| mstatus_o | output | XLEN | New machine status word |
| hstatus_o | output | XLEN | New hypervisor status word |
| swap_o | output | 1 | Request to exchange hypervisor register banks |

## Verification
The bench aims at the priority order where several checks fail at once, for example a supervisor return from user level with a misaligned target. A design with the order swapped would report cause 0 instead of 2. It also covers the boundary between the two supervisor-return paths. A design that restored SPV while virtualized, or that never cleared SPV, would give a wrong virtualization flag, a wrong hypervisor status word or a spurious swap. The zero-rule protection trap is run with MPP set to M and with MPP set to S, which catches a design that traps on the M case or ignores the S case. A machine return without hypervisor support, but with MPV set, shows whether the design wrongly restores virtualization.

// File: rtl/xret_pkg.sv
package xret_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

  // machine status field positions
  localparam int MS_SIE  = 1;
  localparam int MS_MIE  = 3;
  localparam int MS_SPIE = 5;
  localparam int MS_MPIE = 7;
  localparam int MS_SPP  = 8;
  localparam int MS_MPP  = 11;
  localparam int MS_TSR  = 22;
  localparam int MS_MPV  = 39;
  // hypervisor status field positions
  localparam int HS_SPV  = 7;
  localparam int HS_VTSR = 22;
endpackage

// File: rtl/xret_check.sv
module xret_check
  import xret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RULE_W = 5
) (
  input  logic               is_mret,
  input  logic [1:0]         cur_priv,
  input  logic               cur_virt,
  input  logic               tsr,
  input  logic               vtsr,
  input  logic [1:0]         mpp,
  input  logic [XLEN-1:0]    target_pc,
  input  logic               has_c,
  input  logic               has_h,
  input  logic               has_pmp,
  input  logic [RULE_W-1:0]  pmp_rules,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic misaligned;

  assign misaligned = !has_c && (target_pc[1:0] != 2'b00);

  // first failing check in priority order wins
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_MISALIGN;
    if (is_mret) begin
      if (cur_priv != PRIV_M) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1;
        cause = CAUSE_MISALIGN;
      end else if (has_pmp && (pmp_rules == '0) && (mpp != PRIV_M)) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end
    end else begin
      if (cur_priv == PRIV_U) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (misaligned) begin
        fault = 1'b1;
        cause = CAUSE_MISALIGN;
      end else if (tsr && (cur_priv != PRIV_M)) begin
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
      end else if (has_h && cur_virt && vtsr) begin
        fault = 1'b1;
        cause = CAUSE_VIRT;
      end
    end
  end
endmodule

// File: rtl/xret_next.sv
module xret_next
  import xret_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            is_mret,
  input  logic            cur_virt,
  input  logic            has_h,
  input  logic [XLEN-1:0] mstatus,
  input  logic [XLEN-1:0] hstatus,
  output logic [XLEN-1:0] nxt_mstatus,
  output logic [XLEN-1:0] nxt_hstatus,
  output logic [1:0]      nxt_priv,
  output logic            nxt_virt,
  output logic            nxt_swap
);
  always_comb begin
    nxt_mstatus = mstatus;
    nxt_hstatus = hstatus;
    nxt_virt    = cur_virt;
    nxt_swap    = 1'b0;
    if (is_mret) begin
      nxt_priv                    = mstatus[MS_MPP+1:MS_MPP];
      nxt_mstatus[MS_MIE]         = mstatus[MS_MPIE];
      nxt_mstatus[MS_MPIE]        = 1'b1;
      nxt_mstatus[MS_MPP+1:MS_MPP] = PRIV_U;
      nxt_mstatus[MS_MPV]         = 1'b0;
      if (has_h) begin
        nxt_virt = mstatus[MS_MPV];
        nxt_swap = mstatus[MS_MPV];
      end
    end else begin
      nxt_priv             = {1'b0, mstatus[MS_SPP]};
      nxt_mstatus[MS_SIE]  = mstatus[MS_SPIE];
      nxt_mstatus[MS_SPIE] = 1'b1;
      nxt_mstatus[MS_SPP]  = 1'b0;
      if (has_h && !cur_virt) begin
        nxt_virt            = hstatus[HS_SPV];
        nxt_swap            = hstatus[HS_SPV];
        nxt_hstatus[HS_SPV] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xret_unit.sv
module xret_unit
  import xret_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int RULE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_mret,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic [XLEN-1:0]   mstatus_i,
  input  logic [XLEN-1:0]   hstatus_i,
  input  logic [XLEN-1:0]   sepc_i,
  input  logic [XLEN-1:0]   mepc_i,
  input  logic              cfg_has_c,
  input  logic              cfg_has_h,
  input  logic              cfg_has_pmp,
  input  logic [RULE_W-1:0] cfg_pmp_rules,
  output logic              done_o,
  output logic              commit_o,
  output logic              exc_o,
  output logic [4:0]        cause_o,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic [1:0]        priv_o,
  output logic              virt_o,
  output logic [XLEN-1:0]   mstatus_o,
  output logic [XLEN-1:0]   hstatus_o,
  output logic              swap_o
);
  logic [XLEN-1:0]    target_pc;
  logic               fault;
  logic [CAUSE_W-1:0] fault_cause;
  logic [XLEN-1:0]    nxt_mst, nxt_hst;
  logic [1:0]         nxt_priv;
  logic               nxt_virt, nxt_swap;

  assign target_pc = req_is_mret ? mepc_i : sepc_i;

  xret_check #(.XLEN(XLEN), .RULE_W(RULE_W)) u_check (
    .is_mret   (req_is_mret),
    .cur_priv  (cur_priv),
    .cur_virt  (cur_virt),
    .tsr       (mstatus_i[MS_TSR]),
    .vtsr      (hstatus_i[HS_VTSR]),
    .mpp       (mstatus_i[MS_MPP+1:MS_MPP]),
    .target_pc (target_pc),
    .has_c     (cfg_has_c),
    .has_h     (cfg_has_h),
    .has_pmp   (cfg_has_pmp),
    .pmp_rules (cfg_pmp_rules),
    .fault     (fault),
    .cause     (fault_cause)
  );

  xret_next #(.XLEN(XLEN)) u_next (
    .is_mret     (req_is_mret),
    .cur_virt    (cur_virt),
    .has_h       (cfg_has_h),
    .mstatus     (mstatus_i),
    .hstatus     (hstatus_i),
    .nxt_mstatus (nxt_mst),
    .nxt_hstatus (nxt_hst),
    .nxt_priv    (nxt_priv),
    .nxt_virt    (nxt_virt),
    .nxt_swap    (nxt_swap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      commit_o  <= 1'b0;
      exc_o     <= 1'b0;
      swap_o    <= 1'b0;
      cause_o   <= '0;
      ret_pc_o  <= '0;
      priv_o    <= '0;
      virt_o    <= 1'b0;
      mstatus_o <= '0;
      hstatus_o <= '0;
    end else begin
      done_o   <= req_valid;
      commit_o <= req_valid && !fault;
      exc_o    <= req_valid && fault;
      swap_o   <= req_valid && !fault && nxt_swap;
      if (req_valid) begin
        cause_o   <= fault ? fault_cause : '0;
        ret_pc_o  <= target_pc;
        priv_o    <= fault ? cur_priv  : nxt_priv;
        virt_o    <= fault ? cur_virt  : nxt_virt;
        mstatus_o <= fault ? mstatus_i : nxt_mst;
        hstatus_o <= fault ? hstatus_i : nxt_hst;
      end
    end
  end
endmodule

// File: rtl/xret_unit_chk.sv
module xret_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_is_mret,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] mstatus_i,
  input logic            done_o,
  input logic            commit_o,
  input logic            exc_o,
  input logic [4:0]      cause_o,
  input logic [1:0]      priv_o,
  input logic            virt_o,
  input logic [XLEN-1:0] mstatus_o,
  input logic            swap_o
);
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done_o);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!done_o && !commit_o && !exc_o && !swap_o));

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (commit_o ^ exc_o));

  assert_user_sret_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_mret && cur_priv == 2'd0) |=> (exc_o && cause_o == 5'd2));

  assert_mret_stack_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_mret) |=>
      (!commit_o || (priv_o == $past(mstatus_i[12:11]) && mstatus_o[7] && mstatus_o[12:11] == 2'd0 && !mstatus_o[39])));

  assert_swap_with_virt_R11: assert property (@(posedge clk) disable iff (rst)
    swap_o |-> (commit_o && virt_o));

  assert_exc_keeps_state_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!exc_o || (mstatus_o == $past(mstatus_i) && priv_o == $past(cur_priv))));
endmodule

bind xret_unit xret_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_is_mret (req_is_mret),
  .cur_priv    (cur_priv),
  .mstatus_i   (mstatus_i),
  .done_o      (done_o),
  .commit_o    (commit_o),
  .exc_o       (exc_o),
  .cause_o     (cause_o),
  .priv_o      (priv_o),
  .virt_o      (virt_o),
  .mstatus_o   (mstatus_o),
  .swap_o      (swap_o)
);

// File: tb/xret_unit_bench.sv
`timescale 1ns/1ps
module xret_unit_bench;
  localparam int XLEN   = 64;
  localparam int RULE_W = 5;

  typedef struct packed {
    logic            commit;
    logic            exc;
    logic [4:0]      cause;
    logic [XLEN-1:0] pc;
    logic [1:0]      priv;
    logic            virt;
    logic            swap;
    logic [XLEN-1:0] mst;
    logic [XLEN-1:0] hst;
  } res_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_is_mret = 1'b0;
  logic [1:0]        cur_priv = '0;
  logic              cur_virt = 1'b0;
  logic [XLEN-1:0]   mstatus_i = '0, hstatus_i = '0, sepc_i = '0, mepc_i = '0;
  logic              cfg_has_c = 1'b0, cfg_has_h = 1'b0, cfg_has_pmp = 1'b0;
  logic [RULE_W-1:0] cfg_pmp_rules = '0;
  logic              done_o, commit_o, exc_o, virt_o, swap_o;
  logic [4:0]        cause_o;
  logic [XLEN-1:0]   ret_pc_o, mstatus_o, hstatus_o;
  logic [1:0]        priv_o;

  int total = 0;
  int bad = 0;
  int issued = 0;
  int seen = 0;
  res_t  exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  xret_unit #(.XLEN(XLEN), .RULE_W(RULE_W)) u_xret_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_mret(req_is_mret),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .mstatus_i(mstatus_i),
    .hstatus_i(hstatus_i), .sepc_i(sepc_i), .mepc_i(mepc_i),
    .cfg_has_c(cfg_has_c), .cfg_has_h(cfg_has_h), .cfg_has_pmp(cfg_has_pmp),
    .cfg_pmp_rules(cfg_pmp_rules), .done_o(done_o), .commit_o(commit_o),
    .exc_o(exc_o), .cause_o(cause_o), .ret_pc_o(ret_pc_o), .priv_o(priv_o),
    .virt_o(virt_o), .mstatus_o(mstatus_o), .hstatus_o(hstatus_o), .swap_o(swap_o)
  );

  function automatic logic [XLEN-1:0] ms(input logic sie, spie, spp, mie, mpie,
                                         input logic [1:0] mpp, input logic tsr, mpv);
    logic [XLEN-1:0] w = '0;
    w[1] = sie; w[5] = spie; w[8] = spp; w[3] = mie; w[7] = mpie;
    w[12:11] = mpp; w[22] = tsr; w[39] = mpv;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] hs(input logic spv, vtsr);
    logic [XLEN-1:0] w = '0;
    w[7] = spv; w[22] = vtsr;
    return w;
  endfunction

  // reference model written from the requirements
  function automatic res_t model(input logic mret, input logic [1:0] pr, input logic vi,
                                 input logic [XLEN-1:0] m, h, sp, mp,
                                 input logic c, hx, pmp, input logic [RULE_W-1:0] rules);
    res_t r;
    logic [XLEN-1:0] pc = mret ? mp : sp;
    logic mis = !c && (pc[1:0] != 2'b00);
    r = '{commit:1'b0, exc:1'b1, cause:5'd0, pc:pc, priv:pr, virt:vi,
          swap:1'b0, mst:m, hst:h};
    if (mret) begin
      if (pr != 2'd3) r.cause = 5'd2;
      else if (mis) r.cause = 5'd0;
      else if (pmp && rules == 0 && m[12:11] != 2'd3) r.cause = 5'd2;
      else begin
        r.exc = 1'b0; r.commit = 1'b1;
        r.priv = m[12:11];
        r.mst[3] = m[7]; r.mst[7] = 1'b1; r.mst[12:11] = 2'd0; r.mst[39] = 1'b0;
        if (hx) begin r.virt = m[39]; r.swap = m[39]; end
      end
    end else begin
      if (pr == 2'd0) r.cause = 5'd2;
      else if (mis) r.cause = 5'd0;
      else if (m[22] && pr != 2'd3) r.cause = 5'd2;
      else if (hx && vi && h[22]) r.cause = 5'd22;
      else begin
        r.exc = 1'b0; r.commit = 1'b1;
        r.priv = {1'b0, m[8]};
        r.mst[1] = m[5]; r.mst[5] = 1'b1; r.mst[8] = 1'b0;
        if (hx && !vi) begin r.virt = h[7]; r.swap = h[7]; r.hst[7] = 1'b0; end
      end
    end
    return r;
  endfunction

  task automatic issue(input logic mret, input logic [1:0] pr, input logic vi,
                       input logic [XLEN-1:0] m, h, sp, mp,
                       input logic c, hx, pmp, input logic [RULE_W-1:0] rules,
                       input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_is_mret = mret; cur_priv = pr; cur_virt = vi;
    mstatus_i = m; hstatus_i = h; sepc_i = sp; mepc_i = mp;
    cfg_has_c = c; cfg_has_h = hx; cfg_has_pmp = pmp; cfg_pmp_rules = rules;
    exp_q.push_back(model(mret, pr, vi, m, h, sp, mp, c, hx, pmp, rules));
    tag_q.push_back(tag);
    issued++;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done_o) begin
      res_t act, e;
      string t;
      act = '{commit:commit_o, exc:exc_o, cause:cause_o, pc:ret_pc_o, priv:priv_o,
              virt:virt_o, swap:swap_o, mst:mstatus_o, hst:hstatus_o};
      seen++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected result act=%h exp=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          bad++;
          $display("FAIL %s act: c=%b e=%b cause=%0d pc=%h pv=%0d v=%b sw=%b ms=%h hs=%h",
                   t, act.commit, act.exc, act.cause, act.pc, act.priv, act.virt, act.swap, act.mst, act.hst);
          $display("     %s exp: c=%b e=%b cause=%0d pc=%h pv=%0d v=%b sw=%b ms=%h hs=%h",
                   t, e.commit, e.exc, e.cause, e.pc, e.priv, e.virt, e.swap, e.mst, e.hst);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    total++;
    if ({done_o, commit_o, exc_o, swap_o, cause_o, ret_pc_o, priv_o, virt_o, mstatus_o, hstatus_o} !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%b%b%b%b pv=%0d ms=%h exp=all zero",
               done_o, commit_o, exc_o, swap_o, priv_o, mstatus_o);
    end

    // back-to-back stream (R2)
    issue(0, 2'd0, 0, ms(0,1,1,0,0,0,0,0), '0, 64'h1002, 64'h0, 0,0,0,5'd0, "R3 user sret beats misalign");
    issue(0, 2'd1, 0, ms(0,1,1,0,0,0,1,0), '0, 64'h1002, 64'h0, 0,0,0,5'd0, "R4 misalign beats TSR");
    issue(0, 2'd1, 0, ms(0,1,1,0,0,0,1,0), '0, 64'h1002, 64'h0, 1,0,0,5'd0, "R5 TSR at S with C");
    issue(0, 2'd3, 0, ms(1,0,1,0,0,0,1,0), '0, 64'h2000, 64'h0, 0,0,0,5'd0, "R5 R8 TSR at M proceeds");
    issue(0, 2'd1, 1, ms(0,1,0,0,0,0,0,0), hs(1,1), 64'h3000, 64'h0, 0,1,0,5'd0, "R6 virtual trap");
    issue(0, 2'd1, 1, ms(0,1,1,0,0,0,0,0), hs(1,0), 64'h3004, 64'h0, 0,1,0,5'd0, "R8 R11 virtualized sret");
    issue(0, 2'd3, 0, ms(0,1,1,0,0,0,0,0), hs(1,0), 64'h4000, 64'h0, 0,1,0,5'd0, "R7 R11 sret restores SPV");
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    issue(0, 2'd1, 0, ms(1,0,0,0,0,0,0,0), hs(0,1), 64'h4004, 64'h0, 0,1,0,5'd0, "R7 sret to user SPV=0");
    issue(1, 2'd1, 0, ms(0,0,0,0,1,2'd3,0,0), '0, 64'h0, 64'h5000, 0,0,0,5'd0, "R9 mret below M");
    issue(1, 2'd3, 0, ms(0,0,0,0,1,2'd3,0,0), '0, 64'h0, 64'h5001, 0,0,0,5'd0, "R4 mret misaligned");
    issue(1, 2'd3, 0, ms(0,0,0,0,1,2'd1,0,0), '0, 64'h0, 64'h5002, 1,0,1,5'd0, "R10 zero rules to S");
    issue(1, 2'd3, 0, ms(0,0,0,0,1,2'd3,0,0), '0, 64'h0, 64'h5004, 0,0,1,5'd0, "R10 zero rules to M ok");
    issue(1, 2'd3, 0, ms(0,0,0,0,1,2'd1,0,1), '0, 64'h0, 64'h6000, 0,1,1,5'd4, "R9 R11 mret restores MPV");
    issue(1, 2'd3, 0, ms(1,1,1,1,0,2'd0,1,1), '0, 64'h0, 64'h7000, 0,0,0,5'd0, "R9 R12 mret no H keeps virt");
    issue(0, 2'd1, 0, ms(0,1,0,0,0,0,1,0), hs(1,0), 64'h8000, 64'h0, 1,1,0,5'd0, "R12 TSR state unchanged");
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R2: one result per request, nothing left over
    total++;
    if (seen != issued || exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 result count act=%0d exp=%0d", seen, issued);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule